// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display: an active-low horizontal sync, an active-low vertical sync, a display-enable that marks visible pixels, the current pixel and line position, and a one-cycle start-of-frame pulse. It runs one counter step per clock, so the clock it receives is the pixel clock. Clock synthesis, frame-buffer fetch and colour lookup sit outside it. The block only reports which of four pixel clocks and which pixel format software has picked.

Software programs the geometry over a write-only 32-bit bus. Every geometry word carries the line (vertical) quantity in its upper half-word and the pixel (horizontal) quantity in its lower half-word. Writes land in staging registers. They are copied into the working set at a frame boundary, so a running picture never tears.

Along each axis the scan goes through four regions in a fixed order: the visible region, the front porch, the sync pulse, and the back porch. The back porch fills whatever remains up to the programmed total.

Top module: `raster_timing_gen`

## Requirements
- R1: After a synchronous reset, de_o=0, hsync_n_o=1, vsync_n_o=1, sof_o=0, pix_x_o=0, line_y_o=0, fmt_o=0 and clk_sel_o=0, and every staging and working register is zero.
- R2: The bus write addresses are fixed. Address 0 is control, address 1 is totals, address 2 is visible size, address 3 is front porch, and address 4 is sync width. Bits 31:16 of each geometry word are the line value and bits 15:0 are the pixel value. A write to addresses 5 to 7 changes nothing.
- R3: While the working enable bit is 0, de_o=0, hsync_n_o=1, vsync_n_o=1, sof_o=0 and both position outputs are 0.
- R4: While enabled, the pixel counter steps by one per clock from 0 up to the pixel total and then wraps to 0. The line counter steps once per pixel wrap and wraps to 0 after the line total. pix_x_o and line_y_o show the counters one clock late.
- R5: de_o is 1 exactly when the pixel count is at most the visible-pixel value and the line count is at most the visible-line value. Both values are stored as count minus one.
- R6: hsync_n_o is 0 exactly for pixel counts from visible+porch+1 through visible+porch+width, using the pixel halves. A width of 0 gives no pulse.
- R7: vsync_n_o is 0 exactly for line counts from visible+porch+1 through visible+porch+width, using the line halves. The pulse covers whole lines.
- R8: sof_o is high for one clock, in the same clock that reports pixel 0 of line 0.
- R9: The staging registers are copied into the working set on the clock whose counters sit at the last pixel of the last line, and on every clock while the working enable is 0. At all other times the working set holds.
- R10: In the control word, bit 0 enables the scan, bits 5:4 are the pixel format, and bits 7:6 are the pixel-clock select. fmt_o and clk_sel_o show the working copies of those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus word address |
| wr_data | input | 32 | Bus write data |
| de_o | output | 1 | Display enable |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| sof_o | output | 1 | Start-of-frame pulse |
| pix_x_o | output | CNT_W | Pixel position |
| line_y_o | output | CNT_W | Line position |
| fmt_o | output | 2 | Working pixel-format select |
| clk_sel_o | output | 2 | Working pixel-clock select |

## Verification
The assertions check on every clock a set of invariants:
- A counter never passes its total.
- The working set stays stable unless a commit is due.
- A disabled block drives blanked outputs.
- Sync never overlaps display-enable.
- The start-of-frame pulse only appears at the origin with display-enable high.

Several behaviours can only be seen in the bench's scenarios, where a behavioural model is compared against the block on every clock:
- the exact sync and porch placement;
- a geometry change written mid-frame that waits for the frame end;
- a disable that also waits for the frame end;
- writes to unused addresses;
- a zero sync width.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef struct packed {
    logic [15:0] v;
    logic [15:0] h;
  } pair_t;

  localparam int GEOM_N   = 4;
  localparam int IDX_TOT  = 0;
  localparam int IDX_ACT  = 1;
  localparam int IDX_FP   = 2;
  localparam int IDX_SYNC = 3;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_GEOM0 = 1;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_FMT = 4;
  localparam int CTRL_CS  = 6;
endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     commit_i,
  output pair_t [GEOM_N-1:0]       live_o,
  output logic                     live_en_o,
  output logic [1:0]               fmt_o,
  output logic [1:0]               csel_o
);
  pair_t [GEOM_N-1:0] stage_q;
  logic               st_en_q;
  logic [1:0]         st_fmt_q, st_cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      st_en_q  <= 1'b0;
      st_fmt_q <= 2'd0;
      st_cs_q  <= 2'd0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
        st_en_q  <= wr_data[CTRL_EN];
        st_fmt_q <= wr_data[CTRL_FMT +: 2];
        st_cs_q  <= wr_data[CTRL_CS +: 2];
      end
      for (int g = 0; g < GEOM_N; g++) begin
        if (wr_addr == ADDR_W'(ADDR_GEOM0 + g))
          stage_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_o    <= '0;
      live_en_o <= 1'b0;
      fmt_o     <= 2'd0;
      csel_o    <= 2'd0;
    end else if (commit_i) begin
      live_o    <= stage_q;
      live_en_o <= st_en_q;
      fmt_o     <= st_fmt_q;
      csel_o    <= st_cs_q;
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(live_o) && $stable(live_en_o) && $stable(fmt_o) && $stable(csel_o))); // R9
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         at_end
);
  assign at_end = run && (cnt == total);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (step)
      cnt <= at_end ? '0 : cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= total)); // R4
endmodule

// File: rtl/rtg_phase.sv
module rtg_phase #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [15:0]  act,
  input  logic [15:0]  fp,
  input  logic [15:0]  sw,
  output logic         in_act,
  output logic         in_sync
);
  localparam int XW = (W > 16 ? W : 16) + 2;
  logic [XW-1:0] c_x, s_lo, s_hi;

  always_comb begin
    c_x     = XW'(cnt);
    s_lo    = XW'(act) + XW'(fp) + XW'(1);
    s_hi    = XW'(act) + XW'(fp) + XW'(sw);
    in_act  = (c_x <= XW'(act));
    in_sync = (c_x >= s_lo) && (c_x <= s_hi);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              de_o,
  output logic              hsync_n_o,
  output logic              vsync_n_o,
  output logic              sof_o,
  output logic [CNT_W-1:0]  pix_x_o,
  output logic [CNT_W-1:0]  line_y_o,
  output logic [1:0]        fmt_o,
  output logic [1:0]        clk_sel_o
);
  localparam int AXES = 2;

  pair_t [GEOM_N-1:0] live;
  logic               live_en, commit;
  logic [CNT_W-1:0]   cnt    [AXES];
  logic               at_end [AXES];
  logic               in_act [AXES];
  logic               in_sync[AXES];

  rtg_regbank #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_i(commit), .live_o(live), .live_en_o(live_en),
    .fmt_o(fmt_o), .csel_o(clk_sel_o)
  );

  assign commit = !live_en || (at_end[0] && at_end[1]);

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [15:0] tot_a, act_a, fp_a, sw_a;
    logic        step_a;
    assign tot_a = (a == 0) ? live[IDX_TOT].h  : live[IDX_TOT].v;
    assign act_a = (a == 0) ? live[IDX_ACT].h  : live[IDX_ACT].v;
    assign fp_a  = (a == 0) ? live[IDX_FP].h   : live[IDX_FP].v;
    assign sw_a  = (a == 0) ? live[IDX_SYNC].h : live[IDX_SYNC].v;
    if (a == 0) begin : g_pix
      assign step_a = 1'b1;
    end else begin : g_line
      assign step_a = at_end[a-1];
    end

    rtg_axis #(.W(CNT_W)) i_cnt (
      .clk(clk), .rst(rst), .run(live_en), .step(step_a),
      .total(tot_a[CNT_W-1:0]), .cnt(cnt[a]), .at_end(at_end[a])
    );

    rtg_phase #(.W(CNT_W)) i_phase (
      .cnt(cnt[a]), .act(act_a), .fp(fp_a), .sw(sw_a),
      .in_act(in_act[a]), .in_sync(in_sync[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !live_en) begin
      de_o      <= 1'b0;
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      sof_o     <= 1'b0;
      pix_x_o   <= '0;
      line_y_o  <= '0;
    end else begin
      de_o      <= in_act[0] && in_act[1];
      hsync_n_o <= !in_sync[0];
      vsync_n_o <= !in_sync[1];
      sof_o     <= (cnt[0] == '0) && (cnt[1] == '0);
      pix_x_o   <= cnt[0];
      line_y_o  <= cnt[1];
    end
  end

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
    !live_en |=> (!de_o && hsync_n_o && vsync_n_o && !sof_o)); // R3
  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> (pix_x_o == '0 && line_y_o == '0 && de_o)); // R8
  AST_HSYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
    !hsync_n_o |-> !de_o); // R6
  AST_VSYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
    !vsync_n_o |-> !de_o); // R7
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        de_o, hsync_n_o, vsync_n_o, sof_o;
  logic [15:0] pix_x_o, line_y_o;
  logic [1:0]  fmt_o, clk_sel_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .de_o(de_o), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .sof_o(sof_o),
    .pix_x_o(pix_x_o), .line_y_o(line_y_o), .fmt_o(fmt_o), .clk_sel_o(clk_sel_o)
  );

  // behavioural reference model: staged and working words kept as integers
  int s_ctl, l_ctl;
  int s_g[4], l_g[4];   // index 0 totals, 1 visible, 2 porch, 3 sync
  int h, v;
  int e_de, e_hs, e_vs, e_sof, e_x, e_y;

  function automatic int hi(int w); return (w >>> 16) & 32'hffff; endfunction
  function automatic int lo(int w); return w & 32'hffff; endfunction

  always @(posedge clk) begin
    if (rst) begin
      s_ctl = 0; l_ctl = 0; h = 0; v = 0;
      for (int i = 0; i < 4; i++) begin s_g[i] = 0; l_g[i] = 0; end
      e_de = 0; e_hs = 1; e_vs = 1; e_sof = 0; e_x = 0; e_y = 0;
    end else begin
      int en, ht, vt, hlo, hhi, vlo, vhi;
      bit cm;
      en  = l_ctl & 1;
      ht  = lo(l_g[0]); vt = hi(l_g[0]);
      hlo = lo(l_g[1]) + lo(l_g[2]) + 1; hhi = lo(l_g[1]) + lo(l_g[2]) + lo(l_g[3]);
      vlo = hi(l_g[1]) + hi(l_g[2]) + 1; vhi = hi(l_g[1]) + hi(l_g[2]) + hi(l_g[3]);
      if (en != 0) begin
        e_de  = (h <= lo(l_g[1]) && v <= hi(l_g[1])) ? 1 : 0;
        e_hs  = (h >= hlo && h <= hhi) ? 0 : 1;
        e_vs  = (v >= vlo && v <= vhi) ? 0 : 1;
        e_sof = (h == 0 && v == 0) ? 1 : 0;
        e_x = h; e_y = v;
      end else begin
        e_de = 0; e_hs = 1; e_vs = 1; e_sof = 0; e_x = 0; e_y = 0;
      end
      cm = (en == 0) || (h == ht && v == vt);
      if (en != 0) begin
        if (h == ht) begin h = 0; v = (v == vt) ? 0 : v + 1; end
        else h = h + 1;
      end else begin h = 0; v = 0; end
      if (cm) begin
        l_ctl = s_ctl;
        for (int i = 0; i < 4; i++) l_g[i] = s_g[i];
      end
      if (wr_en) begin
        if (wr_addr == 0) s_ctl = int'(wr_data) & 32'hf1;
        else if (wr_addr <= 4) s_g[wr_addr - 1] = int'(wr_data);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    chk(de_o == e_de[0],      "R5", "de",   int'(de_o), e_de);
    chk(hsync_n_o == e_hs[0], "R6", "hs_n", int'(hsync_n_o), e_hs);
    chk(vsync_n_o == e_vs[0], "R7", "vs_n", int'(vsync_n_o), e_vs);
    chk(sof_o == e_sof[0],    "R8", "sof",  int'(sof_o), e_sof);
    chk(int'(pix_x_o) == e_x, "R4", "x",    int'(pix_x_o), e_x);
    chk(int'(line_y_o) == e_y, "R4", "y",   int'(line_y_o), e_y);
    chk(int'(fmt_o) == ((l_ctl >> 4) & 3),     "R10", "fmt",  int'(fmt_o), (l_ctl >> 4) & 3);
    chk(int'(clk_sel_o) == ((l_ctl >> 6) & 3), "R10", "csel", int'(clk_sel_o), (l_ctl >> 6) & 3);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pk(int vv, int hh); return (vv << 16) | hh; endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(de_o == 0 && hsync_n_o == 1 && vsync_n_o == 1 && sof_o == 0, "R1", "blank", int'(de_o), 0);
    chk(pix_x_o == 0 && line_y_o == 0 && fmt_o == 0 && clk_sel_o == 0, "R1", "zero", int'(pix_x_o), 0);
    idle(10);
    // mode A, R2 map: 1 totals, 2 visible, 3 porch, 4 sync
    wr(2, pk(3, 7));
    wr(3, pk(1, 2));
    wr(4, pk(2, 3));
    wr(1, pk(7, 14));
    wr(0, 32'h61);      // R10: enable, format 2, clock 1
    idle(400);
    // R9: mid-frame geometry change waits for the frame end
    wr(2, pk(2, 4));
    wr(3, pk(1, 1));
    wr(4, pk(1, 2));
    wr(1, pk(5, 8));
    wr(0, 32'hd1);
    idle(300);
    // R2: unused addresses change nothing
    wr(5, 32'hffff_ffff);
    wr(6, 32'h0);
    wr(7, 32'h1234_5678);
    idle(60);
    // R3: disable lands at the frame end, then outputs stay blank
    wr(0, 32'h0);
    idle(150);
    chk(de_o == 0 && sof_o == 0 && hsync_n_o == 1, "R3", "idle", int'(de_o), 0);
    // R6: zero sync width gives no pulse
    wr(4, pk(0, 0));
    wr(0, 32'h1);
    idle(200);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule